// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide programming interface that sits in front of three 16-bit counter channels of an interval timer. A host uses a 2-bit address with separate read and write strobes. Address 3 accepts command bytes. Addresses 0, 1 and 2 carry count bytes for the matching channel. The block decodes each channel's access pattern, operating mode and BCD flag. It assembles 16-bit load values from byte writes and hands them to the counters with a one-cycle load pulse. It takes count snapshots and status bytes on command and returns them in the right order.

The counting itself happens outside. Each channel feeds back its live count and its OUT level. The block passes each channel's operating mode and BCD flag out to it. A read is combinational: `rdata` is valid in the cycle `rd_en` is high. Any state the read consumes (a pending latch or a byte toggle) advances at the next clock edge. A write takes effect at the clock edge where `wr_en` is high.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel uses low-then-high access with operating mode 0 and BCD 0. No count or status snapshot is pending, both byte toggles are in the low phase, and `ld_pulse` is 0.
- R2: A write to address 3 whose bits 7:6 are a channel number (0 to 2) and whose bits 5:4 are nonzero sets that channel's access field to bits 5:4, its operating mode to bits 3:1 and its BCD flag to bit 0. Access field 1 means low byte only, 2 means high byte only and 3 means low then high. The new mode and BCD values appear on `ch_mode` (3 bits per channel, channel 0 lowest) and `ch_bcd` from the next cycle.
- R3: A command with access field 0 snapshots the channel's live count and leaves its mode, access field and BCD flag unchanged.
- R4: While a count snapshot or a status snapshot is pending, further snapshot commands for that channel leave the held value unchanged.
- R5: A command whose bits 7:6 equal 3 is a multi-channel read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low requests a count snapshot and bit 4 low requests a status snapshot. Either request can be made without the other.
- R6: A status byte holds OUT in bit 7, 0 in bit 6, the access field in bits 5:4, the operating mode in bits 3:1 and BCD in bit 0. All of these are captured at the moment of the command.
- R7: A data read returns a pending status byte first. If no status byte is pending it returns a pending count snapshot. Otherwise it returns the live count.
- R8: In low-then-high access, a count snapshot is read low byte then high byte and is released after the high byte. In either single-byte access it is released after one read. After release, reads return the live count.
- R9: In low-then-high access, the first data write only stores the low byte. The second write produces `ld_pulse` for one cycle, in the cycle after that write, with `ld_val` = {second byte, first byte}.
- R10: In low-only access a data write loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}. Each write produces a load pulse.
- R11: In low-then-high access, live reads alternate low byte and high byte using a read toggle that data writes do not move.
- R12: A command that sets the access field returns that channel's read and write toggles to the low phase.
- R13: A read of address 3 returns 8'h00 and changes no pending snapshot or toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address: 0 to 2 are channel data, 3 is command |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high |
| cnt_val | input | 48 | Live counts from the channels, 16 bits each, channel 0 lowest |
| ch_out | input | 3 | OUT level of each channel |
| ld_pulse | output | 3 | One-cycle load strobe per channel |
| ld_val | output | 48 | Load value per channel, 16 bits each |
| ch_mode | output | 9 | Operating mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
The hardest state to reach from the ports is one where a channel holds a status snapshot and a count snapshot at once, while its live count and OUT level have since changed. Only that state shows the read order and the no-overwrite rule. The stimulus reaches it by issuing a read-back command, changing `cnt_val` and `ch_out`, and then repeating the command before any read. The read toggle is also driven out of step with the write toggle by interleaving data writes and reads. A command is then issued to show that both toggles return to the low phase.

// File: rtl/tmr_regif.sv
module tmr_regif (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [47:0] cnt_val,
  input  logic [2:0]  ch_out,
  output logic [2:0]  ld_pulse,
  output logic [47:0] ld_val,
  output logic [8:0]  ch_mode,
  output logic [2:0]  ch_bcd
);
  localparam int NCH = 3;
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic [1:0]  acc  [NCH];
  logic [2:0]  md   [NCH];
  logic        bcdq [NCH];
  logic        wtog [NCH];
  logic        rtog [NCH];
  logic [7:0]  wlow [NCH];
  logic [1:0]  clp  [NCH];
  logic [15:0] clv  [NCH];
  logic        stp  [NCH];
  logic [7:0]  stv  [NCH];
  logic [15:0] ldv  [NCH];
  logic [15:0] live [NCH];
  logic [2:0]  ldp;

  wire       cmd_wr = wr_en && addr == CMD_ADDR;
  wire [1:0] csel   = wdata[7:6];
  wire       rbk    = csel == 2'd3;

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (rd_en && addr == 2'(i)) begin
        if (stp[i])               rdata = stv[i];
        else if (clp[i] == 2'd2)  rdata = clv[i][15:8];
        else if (clp[i] != 2'd0)  rdata = clv[i][7:0];
        else if (acc[i] == 2'd2 || (acc[i] == 2'd3 && rtog[i])) rdata = live[i][15:8];
        else                      rdata = live[i][7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldp <= '0;
      for (int i = 0; i < NCH; i++) begin
        acc[i]  <= 2'd3;
        md[i]   <= 3'd0;
        bcdq[i] <= 1'b0;
        wtog[i] <= 1'b0;
        rtog[i] <= 1'b0;
        wlow[i] <= 8'h00;
        clp[i]  <= 2'd0;
        clv[i]  <= 16'h0000;
        stp[i]  <= 1'b0;
        stv[i]  <= 8'h00;
        ldv[i]  <= 16'h0000;
      end
    end else begin
      ldp <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (rd_en && addr == 2'(i)) begin
          if (stp[i])              stp[i] <= 1'b0;
          else if (clp[i] != 2'd0) clp[i] <= (clp[i] == 2'd3) ? 2'd2 : 2'd0;
          else if (acc[i] == 2'd3) rtog[i] <= ~rtog[i];
        end
        if (cmd_wr && !rbk && csel == 2'(i)) begin
          if (wdata[5:4] == 2'd0) begin
            if (clp[i] == 2'd0) begin
              clp[i] <= acc[i];
              clv[i] <= live[i];
            end
          end else begin
            acc[i]  <= wdata[5:4];
            md[i]   <= wdata[3:1];
            bcdq[i] <= wdata[0];
            rtog[i] <= 1'b0;
            wtog[i] <= 1'b0;
          end
        end
        if (cmd_wr && rbk && wdata[1+i]) begin
          if (!wdata[5] && clp[i] == 2'd0) begin
            clp[i] <= acc[i];
            clv[i] <= live[i];
          end
          if (!wdata[4] && !stp[i]) begin
            stp[i] <= 1'b1;
            stv[i] <= {ch_out[i], 1'b0, acc[i], md[i], bcdq[i]};
          end
        end
        if (wr_en && addr == 2'(i)) begin
          case (acc[i])
            2'd1: begin ldp[i] <= 1'b1; ldv[i] <= {8'h00, wdata}; end
            2'd2: begin ldp[i] <= 1'b1; ldv[i] <= {wdata, 8'h00}; end
            default: begin
              if (!wtog[i]) begin
                wlow[i] <= wdata;
                wtog[i] <= 1'b1;
              end else begin
                ldp[i]  <= 1'b1;
                ldv[i]  <= {wdata, wlow[i]};
                wtog[i] <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  assign ld_pulse = ldp;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign live[g]             = cnt_val[16*g +: 16];
    assign ld_val[16*g +: 16]  = ldv[g];
    assign ch_mode[3*g +: 3]   = md[g];
    assign ch_bcd[g]           = bcdq[g];

    AST_LD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      ldp[g] |-> $past(wr_en && addr == 2'(g)));                                      // R9
    AST_LOW_BYTE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'(g) && acc[g] == 2'd3 && !wtog[g]) |=> !ldp[g]);            // R9
    AST_CNT_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (clp[g] != 2'd0 && !(rd_en && addr == 2'(g))) |=> $stable(clv[g]));             // R4
    AST_STAT_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stp[g] && !(rd_en && addr == 2'(g))) |=> (stp[g] && $stable(stv[g])));         // R4
    AST_CMD_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == CMD_ADDR && !wr_en) |=> ($stable(stp[g]) && $stable(clp[g]) && $stable(rtog[g]))); // R13
  end
endmodule

// File: tb/tmr_regif_tb.sv
`timescale 1ns/1ps
module tmr_regif_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  addr = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [15:0] c0 = 0, c1 = 0, c2 = 0;
  logic [2:0]  ch_out = 0;
  logic [2:0]  ld_pulse;
  logic [47:0] ld_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  int total = 0, bad = 0;
  logic [7:0] r;

  always #2 clk = ~clk;

  tmr_regif dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_val({c2, c1, c0}), .ch_out(ch_out),
    .ld_pulse(ld_pulse), .ld_val(ld_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 mode", ch_mode, 9'd0);
    chk("R1 bcd", ch_bcd, 3'd0);
    chk("R1 ld_pulse", ld_pulse, 3'd0);
    c0 = 16'hA55A;
    rd(0, r); chk("R1 low first", r, 8'h5A);
    rd(0, r); chk("R1 high second", r, 8'hA5);
  endtask

  task automatic t_ctrl;
    wr(3, 8'b01_11_010_1);
    chk("R2 mode ch1", ch_mode[5:3], 3'd2);
    chk("R2 bcd ch1", ch_bcd, 3'b010);
    chk("R2 ch0 untouched", ch_mode[2:0], 3'd0);
  endtask

  task automatic t_word_write;
    wr(1, 8'h34); chk("R9 no load on low", ld_pulse, 3'b000);
    wr(1, 8'h12); chk("R9 load pulse", ld_pulse, 3'b010);
    chk("R9 load value", ld_val[31:16], 16'h1234);
    @(negedge clk); chk("R9 one cycle", ld_pulse, 3'b000);
  endtask

  task automatic t_single;
    wr(3, 8'b10_01_000_0);
    wr(2, 8'h5A); chk("R10 low only pulse", ld_pulse, 3'b100);
    chk("R10 low only value", ld_val[47:32], 16'h005A);
    wr(3, 8'b10_10_000_0);
    wr(2, 8'h5A); chk("R10 high only pulse", ld_pulse, 3'b100);
    chk("R10 high only value", ld_val[47:32], 16'h5A00);
  endtask

  task automatic t_live;
    wr(3, 8'h36); c0 = 16'hABCD;
    rd(0, r); chk("R11 low", r, 8'hCD);
    wr(0, 8'h77);
    rd(0, r); chk("R11 write leaves read toggle", r, 8'hAB);
    rd(0, r); chk("R11 wraps to low", r, 8'hCD);
    wr(3, 8'h36);
    rd(0, r); chk("R12 read toggle reset", r, 8'hCD);
    wr(0, 8'h88); chk("R12 write toggle reset no load", ld_pulse, 3'b000);
    wr(0, 8'h99); chk("R12 write toggle reset load", ld_val[15:0], 16'h9988);
  endtask

  task automatic t_latch;
    wr(3, 8'h36); c0 = 16'h1357;
    wr(3, 8'h00); c0 = 16'h2468;
    wr(3, 8'h00);
    chk("R3 mode kept", ch_mode[2:0], 3'd3);
    rd(0, r); chk("R4 snapshot low kept", r, 8'h57);
    rd(0, r); chk("R8 snapshot high", r, 8'h13);
    rd(0, r); chk("R8 released live low", r, 8'h68);
    c2 = 16'hBEEF; wr(3, 8'h80); c2 = 16'h1234;
    rd(2, r); chk("R8 single byte snapshot", r, 8'hBE);
    rd(2, r); chk("R8 single byte released", r, 8'h12);
  endtask

  task automatic t_readback;
    ch_out = 3'b010; c1 = 16'h4321;
    wr(3, 8'hC4);
    c1 = 16'h0000; ch_out = 3'b000;
    rd(1, r); chk("R7 R6 status first", r, 8'hB5);
    rd(1, r); chk("R7 count low", r, 8'h21);
    rd(1, r); chk("R7 count high", r, 8'h43);
    ch_out = 3'b010; c1 = 16'h4321;
    wr(3, 8'hE4); ch_out = 3'b000;
    wr(3, 8'hE4); c1 = 16'h8765;
    rd(1, r); chk("R4 status not overwritten", r, 8'hB5);
    rd(1, r); chk("R5 status only took no count", r, 8'h65);
    c1 = 16'h1111; wr(3, 8'hD4); c1 = 16'h2222;
    rd(1, r); chk("R5 count only low", r, 8'h11);
    rd(1, r); chk("R5 count only high", r, 8'h11);
    rd(1, r); chk("R5 live after", r, 8'h22);
  endtask

  task automatic t_addr3;
    wr(3, 8'hE2);
    rd(3, r); chk("R13 reads zero", r, 8'h00);
    rd(0, r); chk("R13 status still pending", r, 8'h36);
    rd(0, r); chk("R13 toggle unchanged", r, 8'h24);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_word_write;
    t_single;
    t_live;
    t_latch;
    t_readback;
    t_addr3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule